// File: doc/BRIEF.md
# Programmable High/Low Clock Divider

This block divides a fast input clock into a slower clock. The high time and the low time of the output are set separately, each as a whole number of input-clock cycles. Because the two counts are independent, the block can produce odd ratios and asymmetric duty cycles, as well as the even, symmetric case.

Several copies of the divider can share an active-low sync line. While sync is held low, every copy that obeys it stops and parks its output at a chosen start level. When sync is released, each copy waits its own programmed offset and then starts counting. The copies therefore leave sync with a fixed, known skew between them.

A copy can also be set to ignore sync entirely. In that mode it may additionally be pinned to a constant high or low level. A bypass setting idles the counter and passes the input clock straight to the output. Count changes are taken only at period boundaries, so no phase is ever cut short.

Top module: `hl_clk_divider`

## Requirements
- R1: While rst_n is low, with bypass and the force hold off, div_out is 0.
- R2: In steady running, every low phase lasts exactly cfg_low_cnt+1 input cycles. The field is 4 bits, so the low phase ranges from 1 to 16 cycles.
- R3: In steady running, every high phase lasts exactly cfg_high_cnt+1 input cycles. The field is 4 bits, so the high phase ranges from 1 to 16 cycles.
- R4: When cfg_bypass is 1, div_out equals clk_in. Bypass overrides the force hold and sync. When bypass is cleared, the output restarts at the start level, and its first transition follows the same timing as a sync release (R5).
- R5: This requirement applies when cfg_nosync is 0. Take the first rising edge that samples sync_n high as edge 1. The first output transition follows rising edge cfg_phase + L. L is the programmed length of the start-level phase: cfg_high_cnt+1 if the start level is high, cfg_low_cnt+1 if it is low.
- R6: When cfg_nosync is 1 (and the force hold is off), sync_n has no effect: phase widths continue unchanged while sync_n is low.
- R7: When cfg_force_en and cfg_nosync are both 1, div_out is held at cfg_force_level. If cfg_force_en is 1 but cfg_nosync is 0, the force setting has no effect and the divider counts normally.
- R8: While the divider is held by sync (sync_n low, cfg_nosync 0), div_out equals the start level from the first rising edge onward. A cfg_start_high value of 0 gives a low start; a value of 1 gives a high start.
- R9: A new count value is taken only when a full period ends. A period is the start-level phase followed by the opposite phase. A change written mid-period leaves that period's remaining phases at the old widths.
- R10: Take two dividers that share sync and have equal counts but different offsets. After sync is released, their rising edges stay apart by exactly the difference of their offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock that is divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Shared active-low stop/realign line |
| cfg_low_cnt | input | CNT_W | Low phase length minus one |
| cfg_high_cnt | input | CNT_W | High phase length minus one |
| cfg_bypass | input | 1 | Route clk_in to div_out and idle the counter |
| cfg_nosync | input | 1 | Ignore sync_n |
| cfg_force_en | input | 1 | Enable the constant-level hold (needs cfg_nosync) |
| cfg_force_level | input | 1 | Level held while the force hold is active |
| cfg_start_high | input | 1 | First level after a restart: 0 low, 1 high |
| cfg_phase | input | PH_W | Cycles to wait after release before counting |
| div_out | output | 1 | Divided clock, or clk_in when bypassed |

## Verification
The divider level is held in a register, so every transition appears just after a rising edge of clk_in. The bench samples div_out on falling edges and measures phase widths as runs of equal falling-edge samples. Inputs are driven on falling edges, so the first rising edge that sees a released sync line is the next one. The count of falling edges up to the first changed sample therefore equals the offset plus the start-phase length. The bypass path is combinational and is checked one time unit after each clock edge. Hold and park levels appear one rising edge after the hold begins, so they are sampled at the falling edge that follows.

// File: rtl/hl_div_pkg.sv
`timescale 1ns/1ps
package hl_div_pkg;

  typedef enum logic [1:0] {
    ST_HALT = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } div_state_e;

  // Length in input cycles of a phase whose field holds the given value.
  function automatic int unsigned phase_cycles(input int unsigned field);
    return field + 32'd1;
  endfunction

  // A period closes when the phase that ends is the opposite of the start level.
  function automatic logic period_closes(input logic cur_lvl, input logic first_lvl);
    return cur_lvl != first_lvl;
  endfunction

endpackage

// File: rtl/hl_div_ctrl.sv
`timescale 1ns/1ps
module hl_div_ctrl
  import hl_div_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic            clk_in,
  input  logic            rst_n,
  input  logic            sync_n,
  input  logic            bypass,
  input  logic            nosync,
  input  logic            force_en,
  input  logic [PH_W-1:0] phase,
  output logic            halt,
  output logic            forced,
  output logic            run
);

  logic [PH_W-1:0] dly_q;
  logic            sync_hold;
  div_state_e      state;

  assign forced    = force_en & nosync;
  assign sync_hold = ~nosync & ~sync_n;
  assign halt      = bypass | forced | sync_hold;

  always_comb begin
    if (halt)                    state = ST_HALT;
    else if (dly_q != '0)        state = ST_WAIT;
    else                         state = ST_RUN;
  end

  assign run = (state == ST_RUN);

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)              dly_q <= '0;
    else if (halt)           dly_q <= phase;
    else if (dly_q != '0)    dly_q <= dly_q - PH_W'(1);
  end

  // R5: the offset wait counts down one per cycle unless a new hold arrives
  p_wait_count_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
    (state == ST_WAIT) |=> (halt || dly_q == $past(dly_q) - PH_W'(1)));

endmodule

// File: rtl/hl_div_core.sv
`timescale 1ns/1ps
module hl_div_core
  import hl_div_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             halt,
  input  logic             run,
  input  logic             start_high,
  input  logic [CNT_W-1:0] low_cfg,
  input  logic [CNT_W-1:0] high_cfg,
  output logic             lvl
);

  logic             lvl_q;
  logic             start_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lo_q;
  logic [CNT_W-1:0] hi_q;
  logic [CNT_W-1:0] cur_lim;
  logic             phase_done;
  logic             period_end;

  assign cur_lim    = lvl_q ? hi_q : lo_q;
  assign phase_done = run && ((32'(cnt_q) + 32'd1) == phase_cycles(32'(cur_lim)));
  assign period_end = phase_done && period_closes(lvl_q, start_q);
  assign lvl        = lvl_q;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      start_q <= 1'b0;
      cnt_q   <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
    end else if (halt) begin
      lvl_q   <= start_high;
      start_q <= start_high;
      cnt_q   <= '0;
      lo_q    <= low_cfg;
      hi_q    <= high_cfg;
    end else if (run) begin
      if (phase_done) begin
        cnt_q <= '0;
        lvl_q <= ~lvl_q;
        if (period_end) begin
          lo_q <= low_cfg;
          hi_q <= high_cfg;
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  // R2: the running count never passes the limit of the current phase
  p_cnt_bound_r2: assert property (@(posedge clk_in) disable iff (!rst_n)
    cnt_q <= cur_lim);

  // R3: a finished phase flips the level and restarts the count
  p_toggle_restart_r3: assert property (@(posedge clk_in) disable iff (!rst_n)
    phase_done |=> (cnt_q == '0 && lvl_q != $past(lvl_q)));

  // R8: a hold parks the level at the requested start level
  p_halt_start_r8: assert property (@(posedge clk_in) disable iff (!rst_n)
    halt |=> (lvl_q == $past(start_high) && cnt_q == '0));

  // R9: latched counts only move at a period end or during a hold
  p_cfg_hold_r9: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!halt && !period_end) |=> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: rtl/hl_div_outmux.sv
`timescale 1ns/1ps
module hl_div_outmux (
  input  logic clk_in,
  input  logic bypass,
  input  logic forced,
  input  logic force_level,
  input  logic lvl,
  output logic out
);

  always_comb begin
    if (bypass)      out = clk_in;
    else if (forced) out = force_level;
    else             out = lvl;
  end

endmodule

// File: rtl/hl_clk_divider.sv
`timescale 1ns/1ps
module hl_clk_divider #(
  parameter int CNT_W = 4,
  parameter int PH_W  = 4
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             sync_n,
  input  logic [CNT_W-1:0] cfg_low_cnt,
  input  logic [CNT_W-1:0] cfg_high_cnt,
  input  logic             cfg_bypass,
  input  logic             cfg_nosync,
  input  logic             cfg_force_en,
  input  logic             cfg_force_level,
  input  logic             cfg_start_high,
  input  logic [PH_W-1:0]  cfg_phase,
  output logic             div_out
);

  logic halt;
  logic forced;
  logic run;
  logic lvl;

  hl_div_ctrl #(.PH_W(PH_W)) u_ctrl (
    .clk_in   (clk_in),
    .rst_n    (rst_n),
    .sync_n   (sync_n),
    .bypass   (cfg_bypass),
    .nosync   (cfg_nosync),
    .force_en (cfg_force_en),
    .phase    (cfg_phase),
    .halt     (halt),
    .forced   (forced),
    .run      (run)
  );

  hl_div_core #(.CNT_W(CNT_W)) u_core (
    .clk_in     (clk_in),
    .rst_n      (rst_n),
    .halt       (halt),
    .run        (run),
    .start_high (cfg_start_high),
    .low_cfg    (cfg_low_cnt),
    .high_cfg   (cfg_high_cnt),
    .lvl        (lvl)
  );

  hl_div_outmux u_mux (
    .clk_in      (clk_in),
    .bypass      (cfg_bypass),
    .forced      (forced),
    .force_level (cfg_force_level),
    .lvl         (lvl),
    .out         (div_out)
  );

  // R4: while bypassed the counter stays parked and never runs
  p_bypass_idle_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
    cfg_bypass |-> (halt && !run));

endmodule

// File: tb/hl_clk_divider_test.sv
`timescale 1ns/1ps
module hl_clk_divider_test;

  localparam int CLK_P = 10;

  logic       clk_in = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync_n = 1'b1;
  logic [3:0] cfg_low_cnt = '0;
  logic [3:0] cfg_high_cnt = '0;
  logic       cfg_bypass = 1'b0;
  logic       cfg_nosync = 1'b0;
  logic       cfg_force_en = 1'b0;
  logic       cfg_force_level = 1'b0;
  logic       cfg_start_high = 1'b0;
  logic [3:0] cfg_phase = '0;
  logic [3:0] cfg_phase2 = '0;
  logic       div_out;
  logic       div_out2;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_in = ~clk_in;

  hl_clk_divider uut (
    .clk_in(clk_in), .rst_n(rst_n), .sync_n(sync_n),
    .cfg_low_cnt(cfg_low_cnt), .cfg_high_cnt(cfg_high_cnt),
    .cfg_bypass(cfg_bypass), .cfg_nosync(cfg_nosync),
    .cfg_force_en(cfg_force_en), .cfg_force_level(cfg_force_level),
    .cfg_start_high(cfg_start_high), .cfg_phase(cfg_phase),
    .div_out(div_out));

  hl_clk_divider uut2 (
    .clk_in(clk_in), .rst_n(rst_n), .sync_n(sync_n),
    .cfg_low_cnt(cfg_low_cnt), .cfg_high_cnt(cfg_high_cnt),
    .cfg_bypass(cfg_bypass), .cfg_nosync(cfg_nosync),
    .cfg_force_en(cfg_force_en), .cfg_force_level(cfg_force_level),
    .cfg_start_high(cfg_start_high), .cfg_phase(cfg_phase2),
    .div_out(div_out2));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Count falling edges until div_out differs from its current value.
  task automatic first_change(output int n);
    logic s;
    s = div_out;
    n = 0;
    do begin
      @(negedge clk_in);
      n++;
    end while (div_out == s && n < 200);
  endtask

  // Width of the phase that began at the current falling edge.
  task automatic width_run(output int n);
    logic v;
    v = div_out;
    n = 1;
    @(negedge clk_in);
    while (div_out == v && n < 200) begin
      n++;
      @(negedge clk_in);
    end
  endtask

  task automatic hold_sync();
    sync_n = 1'b0;
    repeat (2) @(negedge clk_in);
  endtask

  task automatic release_sync(output int n);
    sync_n = 1'b1;
    first_change(n);
  endtask

  int n;
  int ra [2];
  int rb [2];
  int na, nb, cyc;
  logic pa, pb;
  int bad;

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk_in);
    check("R1 reset level", int'(div_out), 0);
    @(negedge clk_in);
    check("R1 reset level second sample", int'(div_out), 0);
    rst_n = 1'b1;

    // Default counts give divide-by-two
    first_change(n);
    width_run(n);
    check("R3 default high width", n, 1);
    width_run(n);
    check("R2 default low width", n, 1);

    // R2 R3 R5 R8: sweep every count pair
    for (int lo = 0; lo < 16; lo++) begin
      for (int hi = 0; hi < 16; hi++) begin
        hold_sync();
        cfg_low_cnt = 4'(lo);
        cfg_high_cnt = 4'(hi);
        @(negedge clk_in);
        check("R8 parked low start", int'(div_out), 0);
        release_sync(n);
        check("R5 first transition", n, lo + 1);
        width_run(n);
        check("R3 high width", n, hi + 1);
        width_run(n);
        check("R2 low width", n, lo + 1);
        width_run(n);
        check("R3 high width repeat", n, hi + 1);
      end
    end

    // R5 R8: start high with an offset
    hold_sync();
    cfg_start_high = 1'b1;
    cfg_phase = 4'd3;
    cfg_low_cnt = 4'd2;
    cfg_high_cnt = 4'd5;
    @(negedge clk_in);
    check("R8 parked high start", int'(div_out), 1);
    release_sync(n);
    check("R5 offset plus high start phase", n, 3 + 6);
    width_run(n);
    check("R2 low after high start", n, 3);
    width_run(n);
    check("R3 high after high start", n, 6);

    // R9: count change mid-period
    hold_sync();
    cfg_start_high = 1'b0;
    cfg_phase = 4'd0;
    cfg_low_cnt = 4'd1;
    cfg_high_cnt = 4'd1;
    @(negedge clk_in);
    release_sync(n);
    width_run(n);
    cfg_low_cnt = 4'd4;
    cfg_high_cnt = 4'd6;
    width_run(n);
    check("R9 low keeps old width", n, 2);
    width_run(n);
    check("R9 high keeps old width", n, 2);
    width_run(n);
    check("R9 low takes new width", n, 5);
    width_run(n);
    check("R9 high takes new width", n, 7);

    // R6: sync ignored when nosync is set
    hold_sync();
    cfg_low_cnt = 4'd3;
    cfg_high_cnt = 4'd2;
    @(negedge clk_in);
    release_sync(n);
    check("R5 release before nosync", n, 4);
    cfg_nosync = 1'b1;
    sync_n = 1'b0;
    width_run(n);
    check("R6 high width with sync low", n, 3);
    width_run(n);
    check("R6 low width with sync low", n, 4);
    sync_n = 1'b1;

    // R7: force hold
    cfg_force_en = 1'b1;
    cfg_force_level = 1'b1;
    bad = 0;
    @(negedge clk_in);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_in);
      if (div_out !== 1'b1) bad++;
    end
    check("R7 forced high samples off", bad, 0);
    cfg_force_level = 1'b0;
    bad = 0;
    @(negedge clk_in);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_in);
      if (div_out !== 1'b0) bad++;
    end
    check("R7 forced low samples off", bad, 0);
    cfg_force_level = 1'b1;
    cfg_low_cnt = 4'd2;
    cfg_high_cnt = 4'd2;
    @(negedge clk_in);
    cfg_nosync = 1'b0;
    #1;
    check("R7 force without nosync shows start level", int'(div_out), 0);
    first_change(n);
    check("R7 force without nosync counts", n, 3);
    width_run(n);
    check("R7 high width with force ignored", n, 3);
    cfg_force_en = 1'b0;

    // R4: bypass overrides force and sync
    cfg_bypass = 1'b1;
    cfg_nosync = 1'b1;
    cfg_force_en = 1'b1;
    cfg_force_level = 1'b0;
    sync_n = 1'b0;
    bad = 0;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk_in);
      #1;
      if (div_out !== 1'b1) bad++;
      @(negedge clk_in);
      #1;
      if (div_out !== 1'b0) bad++;
    end
    check("R4 bypass follows clk_in", bad, 0);
    cfg_force_en = 1'b0;
    cfg_nosync = 1'b0;
    sync_n = 1'b1;
    cfg_start_high = 1'b1;
    cfg_phase = 4'd2;
    cfg_low_cnt = 4'd3;
    cfg_high_cnt = 4'd1;
    @(negedge clk_in);
    cfg_bypass = 1'b0;
    #1;
    check("R4 restart at start level", int'(div_out), 1);
    first_change(n);
    check("R4 first transition after bypass", n, 2 + 2);

    // R10: skew between two offsets
    hold_sync();
    cfg_start_high = 1'b0;
    cfg_low_cnt = 4'd3;
    cfg_high_cnt = 4'd3;
    cfg_phase = 4'd2;
    cfg_phase2 = 4'd7;
    @(negedge clk_in);
    sync_n = 1'b1;
    pa = div_out;
    pb = div_out2;
    na = 0;
    nb = 0;
    ra[0] = 0; ra[1] = 0; rb[0] = 0; rb[1] = 0;
    cyc = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_in);
      cyc++;
      if (!pa && div_out && na < 2) begin ra[na] = cyc; na++; end
      if (!pb && div_out2 && nb < 2) begin rb[nb] = cyc; nb++; end
      pa = div_out;
      pb = div_out2;
    end
    check("R10 first rise of low offset", ra[0], 2 + 4);
    check("R10 first rise of high offset", rb[0], 7 + 4);
    check("R10 skew second rise", rb[1] - ra[1], 5);
    check("R10 period of low offset", ra[1] - ra[0], 8);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule